// File: doc/BRIEF.md
# Link Ability Negotiation Controller

This block runs the ability exchange between the two ends of a twisted-pair link. It builds the local code word from a four-bit advertisement field and hands that word to a burst codec. It takes the code words the codec decodes from the partner. Once it sees the same partner word several times in a row, it picks the best mode that both ends support, using a fixed four-level priority. It then finishes the handshake by sending its word with the acknowledge bit set.

A restart sends the controller back to the ability phase. The restart causes are a soft reset, a power-down reset, a loss of link, a write of the restart control bit, a change of partner content during the acknowledge phase, or a silence on the receive side that lasts too long. After a restart the advertisement field is sampled again. Writing the advertisement field without a restart does not change the word on the line.

The code word layout is fixed because the codec and the partner decode it:

- Bits [4:0] hold the selector 5'b00001.
- Bits [8:5] hold the abilities: bit 5 is 10M half, bit 6 is 10M full, bit 7 is 100M half and bit 8 is 100M full.
- Bit 14 is the acknowledge bit.
- Bit 15 and bits [13:9] are sent as zero.

The adv_abil input uses the same ability order, from bit 0 (10M half) to bit 3 (100M full).

Top module: `linkneg_fsm`

## Requirements
- R1: While rst_n is low, or while an_enable is low, tx_valid is 0 and tx_word is 0. The first clock edge with rst_n high and an_enable high starts the ability phase. In that phase tx_valid is 1 and tx_word is {1'b0, 1'b0, 5'b0, adv, 5'b00001}, where adv is adv_abil as sampled when the phase began.
- R2: A change on adv_abil does not change tx_word until the next restart. A restart samples adv_abil again.
- R3: When an_enable is high, a high sw_reset, pwrdn_reset or link_down at a clock edge, in any state, returns the block to the ability phase at that edge. This clears an_done and no_match.
- R4: A received word is valid only when rx_valid is 1 and rx_word[4:0] is 5'b00001. The acknowledge phase starts when MATCH_N valid words in a row have identical bits [13:0]. A word with a bad selector, or a valid word with different content, breaks the run. A different valid word starts a new run of length one.
- R5: The mode is chosen from the abilities common to both ends, in this order from highest to lowest: 100M full, 100M half, 10M full, 10M half. res_speed100 is 1 for the two 100M modes. res_full is 1 for the two full-duplex modes.
- R6: In the acknowledge phase, tx_word has bit 14 set. an_done rises after ACK_N received words that carry bit 14 and keep the matched content.
- R7: In the acknowledge phase, a received word whose bits [13:0] differ from the matched word restarts the ability phase at that edge.
- R8: If TIMEOUT clock cycles pass in the ability or acknowledge phase without an accepted word, the ability phase restarts.
- R9: If the two ends share no ability, no_match rises and stays high until a restart. an_done stays 0 and tx_valid is 0 while no_match is high.
- R10: A restart_set pulse makes restart_bit read 1 after the next edge. At the following edge, if an_enable is high, negotiation restarts and restart_bit clears itself.
- R11: partner_word, res_speed100 and res_full read 0 while an_done is 0. While an_done is 1 they hold the matched partner word and the resolved mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| an_enable | input | 1 | Negotiation enable |
| adv_abil | input | 4 | Advertised abilities: bit 3 is 100M full, bit 2 is 100M half, bit 1 is 10M full, bit 0 is 10M half |
| restart_set | input | 1 | Write strobe that sets the restart control bit |
| sw_reset | input | 1 | Soft reset event |
| pwrdn_reset | input | 1 | Power-down reset event |
| link_down | input | 1 | Link lost event |
| restart_bit | output | 1 | Readback of the self-clearing restart bit |
| tx_valid | output | 1 | Local code word is valid for the codec |
| tx_word | output | 16 | Local code word |
| rx_valid | input | 1 | Received word strobe from the codec |
| rx_word | input | 16 | Received partner code word |
| an_done | output | 1 | Negotiation complete |
| no_match | output | 1 | No common ability |
| res_speed100 | output | 1 | Resolved speed is 100M |
| res_full | output | 1 | Resolved duplex is full |
| partner_word | output | 16 | Partner code word, valid when an_done is 1 |

## Verification
The assertions check the following on every cycle:

- The fixed fields of the transmitted word.
- That no_match excludes an_done and transmission.
- That the result outputs are gated by an_done.
- That restart_bit clears itself.
- That each external restart event lands in the ability phase.
- That completion only follows an acknowledged received word.

Some behaviours depend on counting and history, and only the bench scenarios show them:

- Runs of identical words that a bad selector or different content breaks.
- The exact cycle at which the silence timeout fires in the acknowledge phase.
- The order in which the four modes win.
- That the advertisement field is not sampled until a restart.

// File: rtl/linkneg_fsm.sv
module linkneg_fsm #(
  parameter int MATCH_N = 3,
  parameter int ACK_N   = 3,
  parameter int TIMEOUT = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        an_enable,
  input  logic [3:0]  adv_abil,
  input  logic        restart_set,
  input  logic        sw_reset,
  input  logic        pwrdn_reset,
  input  logic        link_down,
  output logic        restart_bit,
  output logic        tx_valid,
  output logic [15:0] tx_word,
  input  logic        rx_valid,
  input  logic [15:0] rx_word,
  output logic        an_done,
  output logic        no_match,
  output logic        res_speed100,
  output logic        res_full,
  output logic [15:0] partner_word
);
  localparam int CW = $clog2(MATCH_N + 1);
  localparam int AW = $clog2(ACK_N + 1);
  localparam int WW = $clog2(TIMEOUT + 1);
  localparam logic [4:0] SEL = 5'b00001;

  typedef enum logic [2:0] {ST_IDLE, ST_ABIL, ST_ACK, ST_DONE, ST_NOMATCH} st_t;

  st_t         st, st_d;
  logic [3:0]  adv_q;
  logic [15:0] last_q, last_d;
  logic [CW-1:0] run_q, run_d, run_nx;
  logic [AW-1:0] ack_q, ack_d;
  logic [WW-1:0] wd_q, wd_d;
  logic        spd_q, spd_d, fdx_q, fdx_d, rbit_q, go;
  logic        evt, sel_ok, same, wd_end;
  logic [3:0]  common;

  assign evt    = sw_reset | pwrdn_reset | link_down | rbit_q;
  assign sel_ok = rx_word[4:0] == SEL;
  assign same   = rx_word[13:0] == last_q[13:0];
  assign wd_end = wd_q == WW'(TIMEOUT - 1);
  assign run_nx = (run_q != '0 && same) ? run_q + 1'b1 : CW'(1);
  assign common = adv_q & rx_word[8:5];

  always_comb begin
    st_d   = st;
    go     = 1'b0;
    last_d = last_q;
    run_d  = run_q;
    ack_d  = ack_q;
    wd_d   = wd_q;
    spd_d  = spd_q;
    fdx_d  = fdx_q;
    if (!an_enable) begin
      st_d = ST_IDLE;
    end else if (evt || st == ST_IDLE) begin
      go = 1'b1;
    end else begin
      case (st)
        ST_ABIL: begin
          if (rx_valid && sel_ok) begin
            wd_d   = '0;
            run_d  = run_nx;
            last_d = rx_word;
            if (run_nx == CW'(MATCH_N)) begin
              if (common == 4'b0) begin
                st_d = ST_NOMATCH;
              end else begin
                st_d  = ST_ACK;
                spd_d = common[3] | common[2];
                fdx_d = common[3] | (~common[2] & common[1]);
              end
            end
          end else begin
            if (rx_valid) run_d = '0;
            if (wd_end) go = 1'b1;
            else wd_d = wd_q + 1'b1;
          end
        end
        ST_ACK: begin
          if (rx_valid) begin
            if (!same) begin
              go = 1'b1;
            end else begin
              wd_d = '0;
              if (rx_word[14]) begin
                ack_d = ack_q + 1'b1;
                if (ack_q + 1'b1 == AW'(ACK_N)) st_d = ST_DONE;
              end
            end
          end else if (wd_end) begin
            go = 1'b1;
          end else begin
            wd_d = wd_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      adv_q  <= '0;
      last_q <= '0;
      run_q  <= '0;
      ack_q  <= '0;
      wd_q   <= '0;
      spd_q  <= 1'b0;
      fdx_q  <= 1'b0;
      rbit_q <= 1'b0;
    end else begin
      rbit_q <= restart_set | (rbit_q & ~go);
      if (go) begin
        st     <= ST_ABIL;
        adv_q  <= adv_abil;
        last_q <= '0;
        run_q  <= '0;
        ack_q  <= '0;
        wd_q   <= '0;
        spd_q  <= 1'b0;
        fdx_q  <= 1'b0;
      end else begin
        st     <= st_d;
        last_q <= last_d;
        run_q  <= run_d;
        ack_q  <= ack_d;
        wd_q   <= wd_d;
        spd_q  <= spd_d;
        fdx_q  <= fdx_d;
      end
    end
  end

  assign restart_bit  = rbit_q;
  assign tx_valid     = st == ST_ABIL || st == ST_ACK;
  assign tx_word      = tx_valid ? {1'b0, st == ST_ACK, 5'b0, adv_q, SEL} : 16'h0;
  assign an_done      = st == ST_DONE;
  assign no_match     = st == ST_NOMATCH;
  assign res_speed100 = an_done & spd_q;
  assign res_full     = an_done & fdx_q;
  assign partner_word = an_done ? last_q : 16'h0;
endmodule

// File: rtl/linkneg_fsm_chk.sv
module linkneg_fsm_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        an_enable,
  input logic        sw_reset,
  input logic        pwrdn_reset,
  input logic        link_down,
  input logic        restart_set,
  input logic        restart_bit,
  input logic        rx_valid,
  input logic        rx_ack,
  input logic        tx_valid,
  input logic [15:0] tx_word,
  input logic        an_done,
  input logic        no_match,
  input logic        res_speed100,
  input logic        res_full,
  input logic [15:0] partner_word
);
  assert_tx_fields_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_word[4:0] == 5'b00001 && !tx_word[15] && tx_word[13:9] == 5'b0));

  assert_tx_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid |-> tx_word == 16'h0);

  assert_event_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (an_enable && (sw_reset || pwrdn_reset || link_down))
      |=> (tx_valid && !tx_word[14] && !an_done && !no_match));

  assert_done_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(an_done) |-> $past(rx_valid && rx_ack));

  assert_nomatch_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    no_match |-> (!an_done && !tx_valid));

  assert_bit_selfclear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_bit && an_enable && !restart_set) |=> !restart_bit);

  assert_result_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !an_done |-> (partner_word == 16'h0 && !res_speed100 && !res_full));
endmodule

bind linkneg_fsm linkneg_fsm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .an_enable(an_enable), .sw_reset(sw_reset),
  .pwrdn_reset(pwrdn_reset), .link_down(link_down), .restart_set(restart_set),
  .restart_bit(restart_bit), .rx_valid(rx_valid), .rx_ack(rx_word[14]),
  .tx_valid(tx_valid), .tx_word(tx_word), .an_done(an_done), .no_match(no_match),
  .res_speed100(res_speed100), .res_full(res_full), .partner_word(partner_word)
);

// File: tb/linkneg_fsm_tb.sv
module linkneg_fsm_tb;
  localparam int MN = 3, AN = 3, TO = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0, an_enable = 1'b1, restart_set = 1'b0;
  logic sw_reset = 1'b0, pwrdn_reset = 1'b0, link_down = 1'b0;
  logic [3:0] adv_abil = 4'hF;
  logic rx_valid = 1'b0;
  logic [15:0] rx_word = 16'h0;
  logic restart_bit, tx_valid, an_done, no_match, res_speed100, res_full;
  logic [15:0] tx_word, partner_word;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  linkneg_fsm #(.MATCH_N(MN), .ACK_N(AN), .TIMEOUT(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .an_enable(an_enable), .adv_abil(adv_abil),
    .restart_set(restart_set), .sw_reset(sw_reset), .pwrdn_reset(pwrdn_reset),
    .link_down(link_down), .restart_bit(restart_bit), .tx_valid(tx_valid),
    .tx_word(tx_word), .rx_valid(rx_valid), .rx_word(rx_word), .an_done(an_done),
    .no_match(no_match), .res_speed100(res_speed100), .res_full(res_full),
    .partner_word(partner_word));

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] cw(logic [3:0] ab, logic ack);
    return {1'b0, ack, 5'b0, ab, 5'b00001};
  endfunction

  // behavioural reference: 0 idle, 1 ability, 2 acknowledge, 3 done, 4 no match
  int m_st = 0, m_run = 0, m_ack = 0, m_wd = 0;
  logic [3:0] m_adv = 0;
  logic [15:0] m_last = 0;
  bit m_spd = 0, m_fdx = 0, m_rbit = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_run = 0; m_ack = 0; m_wd = 0; m_adv = 0; m_last = 0;
      m_spd = 0; m_fdx = 0; m_rbit = 0;
    end else begin
      bit restart;
      logic [3:0] c;
      restart = 0;
      if (!an_enable) m_st = 0;
      else if (sw_reset || pwrdn_reset || link_down || m_rbit || m_st == 0) restart = 1;
      else if (m_st == 1) begin
        if (rx_valid && rx_word[4:0] == 5'd1) begin
          m_wd = 0;
          if (m_run > 0 && rx_word[13:0] == m_last[13:0]) m_run++; else m_run = 1;
          m_last = rx_word;
          if (m_run == MN) begin
            c = m_adv & rx_word[8:5];
            if (c == 0) m_st = 4;
            else begin
              m_st = 2;
              m_spd = c[3] || c[2];
              m_fdx = c[3] || (!c[2] && c[1]);
            end
          end
        end else begin
          if (rx_valid) m_run = 0;
          if (m_wd == TO - 1) restart = 1; else m_wd++;
        end
      end else if (m_st == 2) begin
        if (rx_valid) begin
          if (rx_word[13:0] != m_last[13:0]) restart = 1;
          else begin
            m_wd = 0;
            if (rx_word[14]) begin m_ack++; if (m_ack == AN) m_st = 3; end
          end
        end else if (m_wd == TO - 1) restart = 1;
        else m_wd++;
      end
      m_rbit = restart_set || (m_rbit && !restart);
      if (restart) begin
        m_st = 1; m_adv = adv_abil; m_run = 0; m_ack = 0; m_wd = 0; m_last = 0;
        m_spd = 0; m_fdx = 0;
      end
    end
  end

  always @(negedge clk) begin
    logic ev;
    logic dn;
    ev = (m_st == 1 || m_st == 2);
    dn = (m_st == 3);
    chk("R1", "tx_valid", tx_valid, ev);
    chk("R2", "tx_word", tx_word, ev ? cw(m_adv, m_st == 2) : 16'h0);
    chk("R6", "an_done", an_done, dn);
    chk("R9", "no_match", no_match, m_st == 4);
    chk("R5", "res_speed100", res_speed100, dn && m_spd);
    chk("R5", "res_full", res_full, dn && m_fdx);
    chk("R11", "partner_word", partner_word, dn ? m_last : 16'h0);
    chk("R10", "restart_bit", restart_bit, m_rbit);
  end

  task automatic send(logic [15:0] w);
    rx_valid = 1'b1; rx_word = w;
    @(negedge clk);
    rx_valid = 1'b0; rx_word = 16'h0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_restart(logic [3:0] adv);
    adv_abil = adv;
    restart_set = 1'b1; @(negedge clk); restart_set = 1'b0; @(negedge clk);
  endtask

  task automatic negotiate(logic [3:0] adv, logic [3:0] pa);
    do_restart(adv);
    repeat (MN) send(cw(pa, 1'b0));
    repeat (AN) send(cw(pa, 1'b1));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    idle(3);
    chk("R1", "tx_valid in reset", tx_valid, 0);
    chk("R1", "tx_word in reset", tx_word, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "tx_word after reset", tx_word, 16'h01E1);

    repeat (2) send(cw(4'hF, 0));
    chk("R4", "still ability phase", tx_word[14], 0);
    send(cw(4'hF, 0));
    chk("R6", "ack word sent", tx_word, 16'h41E1);
    repeat (2) send(cw(4'hF, 1));
    chk("R6", "not done early", an_done, 0);
    chk("R11", "partner hidden", partner_word, 0);
    send(cw(4'hF, 1));
    chk("R6", "done", an_done, 1);
    chk("R5", "100 full speed", res_speed100, 1);
    chk("R5", "100 full duplex", res_full, 1);
    chk("R11", "partner word", partner_word, 16'h01E1);

    restart_set = 1'b1; @(negedge clk); restart_set = 1'b0;
    chk("R10", "bit set", restart_bit, 1);
    @(negedge clk);
    chk("R10", "bit cleared", restart_bit, 0);
    chk("R3", "done cleared", an_done, 0);
    adv_abil = 4'b0001;
    idle(3);
    chk("R2", "adv not taken", tx_word, 16'h01E1);
    do_restart(4'b0001);
    chk("R2", "adv taken", tx_word, 16'h0021);

    negotiate(4'b0110, 4'b0111);
    chk("R5", "100 half speed", res_speed100, 1);
    chk("R5", "100 half duplex", res_full, 0);
    negotiate(4'b0011, 4'b1010);
    chk("R5", "10 full speed", res_speed100, 0);
    chk("R5", "10 full duplex", res_full, 1);
    negotiate(4'b1001, 4'b0101);
    chk("R5", "10 half done", an_done, 1);
    chk("R5", "10 half duplex", res_full, 0);
    negotiate(4'b1010, 4'b1111);
    chk("R5", "100 full wins", res_full & res_speed100, 1);

    do_restart(4'hF);
    send(cw(4'hF, 0)); send(cw(4'hF, 0)); send(16'h01E2);
    send(cw(4'hF, 0)); send(cw(4'hF, 0));
    chk("R4", "bad selector breaks run", tx_word[14], 0);
    send(cw(4'h3, 0)); send(cw(4'h3, 0));
    chk("R4", "new content restarts run", tx_word[14], 0);
    send(cw(4'h3, 0));
    chk("R4", "match reached", tx_word[14], 1);
    send(cw(4'hF, 1));
    chk("R7", "content change restarts", tx_word, 16'h01E1);

    repeat (MN) send(cw(4'h3, 0));
    chk("R8", "in ack phase", tx_word[14], 1);
    idle(TO - 1);
    chk("R8", "before timeout", tx_word[14], 1);
    idle(1);
    chk("R8", "after timeout", tx_word, 16'h01E1);

    do_restart(4'b1000);
    repeat (MN) send(cw(4'b0001, 0));
    chk("R9", "no match", no_match, 1);
    chk("R9", "no done", an_done, 0);
    chk("R9", "tx quiet", tx_valid, 0);
    idle(TO + 5);
    chk("R9", "no match held", no_match, 1);
    link_down = 1'b1; @(negedge clk); link_down = 1'b0;
    chk("R3", "link down restart", tx_valid, 1);
    chk("R3", "no match cleared", no_match, 0);

    negotiate(4'hF, 4'hF);
    sw_reset = 1'b1; @(negedge clk); sw_reset = 1'b0;
    chk("R3", "soft reset restart", an_done, 0);
    negotiate(4'hF, 4'hF);
    pwrdn_reset = 1'b1; @(negedge clk); pwrdn_reset = 1'b0;
    chk("R3", "power down restart", tx_valid, 1);

    an_enable = 1'b0; @(negedge clk);
    chk("R1", "disabled quiet", tx_valid, 0);
    an_enable = 1'b1; @(negedge clk);
    chk("R1", "enable starts", tx_valid, 1);
    idle(2);
    summary();
    $finish;
  end
endmodule